// File: doc/BRIEF.md
# Partitioned Shared-SRAM Dual FIFO Controller

This block turns one single-port SRAM of `2**AW` words into two independent FIFOs. The low region of the address space buffers data that a serial flash engine reads and a system bus then collects. The high region buffers data that the system bus supplies and the flash engine later drains. A configuration value sets how many words the low region owns; the high region takes every remaining word and starts right above the low one. The block does not hold the array or arbitrate its port. It produces SRAM addresses and strobes for the four accesses, tracks head, tail and occupancy for each side, and reports fill levels and full and empty flags.

Data leaving toward the system bus never passes combinationally from the SRAM output. A one-entry holding register sits in that path. It prefetches the oldest word as soon as one is stored, and it counts toward the low FIFO's capacity. The low FIFO therefore holds one word more than its share of the array. Writing a new legal boundary empties both FIFOs. Boundary values of zero and all-ones are rejected.

Top module: `split_sram_fifo`

## Requirements
- R1: After reset the boundary is `2**AW/2`. Both fill levels read 0, `rd_full`, `wr_full` and `bus_rvalid` are low and `wr_empty` is high. The first write-side push addresses word `2**AW/2` and the first read-side push addresses word 0.
- R2: The read FIFO holds boundary+1 entries. `rd_full` rises when `rd_fill` equals boundary+1. A flash push while `rd_full` is high produces no SRAM write and leaves `rd_fill` unchanged.
- R3: The write FIFO holds `2**AW` minus the boundary. `wr_full` rises when `wr_fill` reaches that value. A bus push while full and a flash pop while `wr_empty` is high are both ignored: no SRAM strobe, and the fill level is unchanged.
- R4: Read-side SRAM addresses, for both the write and the read strobes, run 0, 1, ... boundary-1 and then wrap to 0. Write-side addresses run from the boundary up to `2**AW-1` and then wrap back to the boundary.
- R5: `bus_rdata` comes from a holding register. That register is loaded from `sram_rdata` at the edge one cycle after `rd_sram_re`. Entries leave in the order they were pushed. `bus_rvalid` and `bus_rdata` stay unchanged until `bus_rd_pop` is high while valid.
- R6: `rd_fill` counts the words in the read region plus the holding register, including a word whose SRAM read is still in flight. `wr_fill` counts the words in the write region. Both show the low `AW` bits of an `AW+1`-bit count and change at the clock edge that accepts the push or pop.
- R7: A configuration write of a value from 1 to `2**AW-2` sets the boundary at that edge. It also empties both FIFOs and the holding register, and both pointer pairs restart at the start of their regions.
- R8: A configuration write of 0 or `2**AW-1` is ignored. The boundary, both FIFOs' contents and all pointers stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_part | input | AW | New boundary (words owned by the read FIFO) |
| fl_rd_push | input | 1 | Flash engine stores one word into the read FIFO |
| rd_sram_we | output | 1 | SRAM write strobe for the read FIFO's push |
| rd_sram_waddr | output | AW | SRAM address for that write |
| rd_sram_re | output | 1 | SRAM read strobe for prefetch into the holding register |
| rd_sram_raddr | output | AW | SRAM address for that read |
| sram_rdata | input | DW | SRAM read data, valid one cycle after a read strobe |
| bus_rd_pop | input | 1 | System bus takes the word in the holding register |
| bus_rvalid | output | 1 | Holding register contains a word |
| bus_rdata | output | DW | Holding register contents |
| rd_full | output | 1 | Read FIFO at capacity |
| rd_fill | output | AW | Read FIFO fill level, low AW bits |
| bus_wr_push | input | 1 | System bus stores one word into the write FIFO |
| wr_sram_we | output | 1 | SRAM write strobe for the write FIFO's push |
| wr_sram_waddr | output | AW | SRAM address for that write |
| fl_wr_pop | input | 1 | Flash engine takes one word from the write FIFO |
| wr_sram_re | output | 1 | SRAM read strobe for that pop |
| wr_sram_raddr | output | AW | SRAM address for that read |
| wr_full | output | 1 | Write FIFO at capacity |
| wr_empty | output | 1 | Write FIFO holds nothing |
| wr_fill | output | AW | Write FIFO fill level, low AW bits |

## Verification
The bench works on a 16-word array and sweeps every legal boundary. For each boundary it fills both FIFOs to capacity, pushes once more, and drains them twice. The second pass starts where the first left off, so every wrap point is crossed. A design that forgot to count the holding register would raise `rd_full` one push early. A design that wrapped on a power of two instead of the region size would send read-side addresses into the write region, or write-side addresses past the top of the array. Data order through the prefetch path is compared word by word, and the bench stalls the bus to show that the held word does not change. An unqualified configuration would wipe both FIFOs on an illegal write or move the write base, and the bench checks for both.

// File: rtl/spf_pkg.sv
package spf_pkg;

    // Occupancy of the read-side holding register
    typedef enum logic [1:0] {
        HOLD_EMPTY = 2'd0,   // nothing held, no read outstanding
        HOLD_PEND  = 2'd1,   // SRAM read issued, data lands next edge
        HOLD_FULL  = 2'd2    // word held and presented to the bus
    } hold_st_e;

    // A boundary is usable only if both regions keep at least one word
    function automatic logic part_is_legal(input logic [15:0] v, input int unsigned aw);
        logic [15:0] top;
        top = 16'((32'd1 << aw) - 32'd1);
        return (v != 16'd0) && (v != top);
    endfunction

endpackage

// File: rtl/spf_part_reg.sv
module spf_part_reg #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_part,
    output logic [AW-1:0] part,
    output logic          clr
);
    localparam logic [AW-1:0] PART_RST = AW'(1) << (AW - 1);

    typedef struct packed {
        logic [AW-1:0] part;
    } part_t;

    part_t part_d, part_q;
    logic  accept;

    always_comb begin
        accept = cfg_we && spf_pkg::part_is_legal(16'(cfg_part), AW);
        part_d = part_q;
        if (accept) begin
            part_d.part = cfg_part;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q.part <= PART_RST;
        end else begin
            part_q <= part_d;
        end
    end

    assign part = part_q.part;
    assign clr  = accept;
endmodule

// File: rtl/spf_ring.sv
module spf_ring #(
    parameter int unsigned AW = 8,
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] size,
    input  logic          push,
    input  logic          pop,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wp,
    output logic [AW-1:0] rp,
    output logic [CW-1:0] cnt
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  at_cap;
    logic  is_void;

    // Advance a pointer, wrapping at the region size rather than a power of two
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [CW-1:0] sz);
        logic [CW-1:0] n;
        n = {1'b0, p} + CW'(1);
        return (n >= sz) ? '0 : n[AW-1:0];
    endfunction

    always_comb begin
        at_cap  = (ring_q.cnt >= size);
        is_void = (ring_q.cnt == '0);
        pop_ok  = pop && !is_void;
        push_ok = push && (!at_cap || pop_ok);

        ring_d = ring_q;
        if (clr) begin
            ring_d = '0;
        end else begin
            if (push_ok) begin
                ring_d.wp = step(ring_q.wp, size);
            end
            if (pop_ok) begin
                ring_d.rp = step(ring_q.rp, size);
            end
            ring_d.cnt = ring_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign wp  = ring_q.wp;
    assign rp  = ring_q.rp;
    assign cnt = ring_q.cnt;
endmodule

// File: rtl/spf_hold.sv
module spf_hold #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          src_avail,
    input  logic          pop,
    input  logic [DW-1:0] sram_rdata,
    output logic          issue,
    output logic          valid,
    output logic          occupied,
    output logic [DW-1:0] data
);
    import spf_pkg::*;

    typedef struct packed {
        hold_st_e      st;
        logic [DW-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  take;

    always_comb begin
        take  = pop && (hold_q.st == HOLD_FULL);
        // Refill when the slot is free now or is being vacated this cycle
        issue = !clr && src_avail &&
                ((hold_q.st == HOLD_EMPTY) || take);

        hold_d = hold_q;
        if (clr) begin
            hold_d.st = HOLD_EMPTY;
        end else begin
            case (hold_q.st)
                HOLD_EMPTY: hold_d.st = issue ? HOLD_PEND : HOLD_EMPTY;
                HOLD_PEND: begin
                    hold_d.st   = HOLD_FULL;
                    hold_d.data = sram_rdata;
                end
                HOLD_FULL: begin
                    if (take) begin
                        hold_d.st = issue ? HOLD_PEND : HOLD_EMPTY;
                    end
                end
                default: hold_d.st = HOLD_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.st   <= HOLD_EMPTY;
            hold_q.data <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign valid    = (hold_q.st == HOLD_FULL);
    assign occupied = (hold_q.st != HOLD_EMPTY);
    assign data     = hold_q.data;
endmodule

// File: rtl/split_sram_fifo.sv
module split_sram_fifo #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_part,
    input  logic          fl_rd_push,
    output logic          rd_sram_we,
    output logic [AW-1:0] rd_sram_waddr,
    output logic          rd_sram_re,
    output logic [AW-1:0] rd_sram_raddr,
    input  logic [DW-1:0] sram_rdata,
    input  logic          bus_rd_pop,
    output logic          bus_rvalid,
    output logic [DW-1:0] bus_rdata,
    output logic          rd_full,
    output logic [AW-1:0] rd_fill,
    input  logic          bus_wr_push,
    output logic          wr_sram_we,
    output logic [AW-1:0] wr_sram_waddr,
    input  logic          fl_wr_pop,
    output logic          wr_sram_re,
    output logic [AW-1:0] wr_sram_raddr,
    output logic          wr_full,
    output logic          wr_empty,
    output logic [AW-1:0] wr_fill
);
    localparam int unsigned CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(1) << AW;

    logic [AW-1:0] part;
    logic          clr;
    logic [CW-1:0] rd_size, wr_size;
    logic [CW-1:0] rd_cnt, wr_cnt, rd_total;
    logic [AW-1:0] rd_wp, rd_rp, wr_wp, wr_rp;
    logic          rd_push_in, hold_issue, hold_occ;

    spf_part_reg #(.AW(AW)) u_part (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_part (cfg_part),
        .part     (part),
        .clr      (clr)
    );

    always_comb begin
        rd_size    = {1'b0, part};
        wr_size    = DEPTH_C - {1'b0, part};
        rd_total   = rd_cnt + CW'(hold_occ);
        rd_full    = (rd_total == rd_size + CW'(1));
        rd_push_in = fl_rd_push && !rd_full && !clr;
    end

    // Low region: flash pushes, prefetch pops into the holding register
    spf_ring #(.AW(AW)) u_rd_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .size    (rd_size),
        .push    (rd_push_in),
        .pop     (hold_issue),
        .push_ok (rd_sram_we),
        .pop_ok  (rd_sram_re),
        .wp      (rd_wp),
        .rp      (rd_rp),
        .cnt     (rd_cnt)
    );

    spf_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .src_avail  (rd_cnt != '0),
        .pop        (bus_rd_pop),
        .sram_rdata (sram_rdata),
        .issue      (hold_issue),
        .valid      (bus_rvalid),
        .occupied   (hold_occ),
        .data       (bus_rdata)
    );

    // High region: bus pushes, flash pops
    spf_ring #(.AW(AW)) u_wr_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .size    (wr_size),
        .push    (bus_wr_push && !clr),
        .pop     (fl_wr_pop && !clr),
        .push_ok (wr_sram_we),
        .pop_ok  (wr_sram_re),
        .wp      (wr_wp),
        .rp      (wr_rp),
        .cnt     (wr_cnt)
    );

    always_comb begin
        rd_sram_waddr = rd_wp;
        rd_sram_raddr = rd_rp;
        wr_sram_waddr = part + wr_wp;
        wr_sram_raddr = part + wr_rp;
        rd_fill       = rd_total[AW-1:0];
        wr_fill       = wr_cnt[AW-1:0];
        wr_full       = (wr_cnt == wr_size);
        wr_empty      = (wr_cnt == '0);
    end
endmodule

// File: rtl/split_sram_fifo_chk.sv
module split_sram_fifo_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_part,
    input logic [AW-1:0] part,
    input logic          fl_rd_push,
    input logic          rd_sram_we,
    input logic [AW-1:0] rd_sram_waddr,
    input logic          rd_sram_re,
    input logic [AW-1:0] rd_sram_raddr,
    input logic          bus_rd_pop,
    input logic          bus_rvalid,
    input logic [DW-1:0] bus_rdata,
    input logic          rd_full,
    input logic [AW-1:0] rd_fill,
    input logic          bus_wr_push,
    input logic          wr_sram_we,
    input logic [AW-1:0] wr_sram_waddr,
    input logic          fl_wr_pop,
    input logic          wr_full,
    input logic [AW-1:0] wr_fill
);
    logic legal_cfg;
    assign legal_cfg = cfg_we && (cfg_part != '0) && (cfg_part != '1);

    // R2: a full read FIFO reports boundary+1 words
    a_r2_rd_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        rd_full |-> (rd_fill == part + AW'(1)));

    // R2: a push into a full read FIFO changes nothing
    a_r2_rd_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_full && fl_rd_push && !bus_rd_pop && !cfg_we) |=> $stable(rd_fill));

    // R3: a push into a full write FIFO changes nothing
    a_r3_wr_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && bus_wr_push && !fl_wr_pop && !cfg_we) |=> $stable(wr_fill));

    // R4: read-side stores stay below the boundary
    a_r4_rd_region: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sram_we |-> (rd_sram_waddr < part));

    // R4: prefetch reads stay below the boundary
    a_r4_rd_fetch_region: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sram_re |-> (rd_sram_raddr < part));

    // R4: write-side stores stay at or above the boundary
    a_r4_wr_region: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sram_we |-> (wr_sram_waddr >= part));

    // R5: held word is stable until taken
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && !bus_rd_pop && !cfg_we) |=> (bus_rvalid && $stable(bus_rdata)));

    // R6: an empty read FIFO presents nothing
    a_r6_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_fill == '0) && !rd_full) |-> !bus_rvalid);

    // R7: a legal boundary write empties both sides
    a_r7_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        legal_cfg |=> ((rd_fill == '0) && (wr_fill == '0) && !bus_rvalid));

    // R8: an illegal boundary write keeps the boundary
    a_r8_cfg_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !legal_cfg) |=> $stable(part));
endmodule

bind split_sram_fifo split_sram_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_part      (cfg_part),
    .part          (part),
    .fl_rd_push    (fl_rd_push),
    .rd_sram_we    (rd_sram_we),
    .rd_sram_waddr (rd_sram_waddr),
    .rd_sram_re    (rd_sram_re),
    .rd_sram_raddr (rd_sram_raddr),
    .bus_rd_pop    (bus_rd_pop),
    .bus_rvalid    (bus_rvalid),
    .bus_rdata     (bus_rdata),
    .rd_full       (rd_full),
    .rd_fill       (rd_fill),
    .bus_wr_push   (bus_wr_push),
    .wr_sram_we    (wr_sram_we),
    .wr_sram_waddr (wr_sram_waddr),
    .fl_wr_pop     (fl_wr_pop),
    .wr_full       (wr_full),
    .wr_fill       (wr_fill)
);

// File: tb/split_sram_fifo_test.sv
module split_sram_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_part = '0;
    logic          fl_rd_push = 1'b0;
    logic          rd_sram_we, rd_sram_re;
    logic [AW-1:0] rd_sram_waddr, rd_sram_raddr;
    logic [DW-1:0] sram_rdata = '0;
    logic          bus_rd_pop = 1'b0;
    logic          bus_rvalid;
    logic [DW-1:0] bus_rdata;
    logic          rd_full;
    logic [AW-1:0] rd_fill;
    logic          bus_wr_push = 1'b0;
    logic          wr_sram_we, wr_sram_re;
    logic [AW-1:0] wr_sram_waddr, wr_sram_raddr;
    logic          fl_wr_pop = 1'b0;
    logic          wr_full, wr_empty;
    logic [AW-1:0] wr_fill;

    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] mem [DEPTH];

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    split_sram_fifo #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_part(cfg_part),
        .fl_rd_push(fl_rd_push), .rd_sram_we(rd_sram_we), .rd_sram_waddr(rd_sram_waddr),
        .rd_sram_re(rd_sram_re), .rd_sram_raddr(rd_sram_raddr), .sram_rdata(sram_rdata),
        .bus_rd_pop(bus_rd_pop), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .rd_full(rd_full), .rd_fill(rd_fill), .bus_wr_push(bus_wr_push),
        .wr_sram_we(wr_sram_we), .wr_sram_waddr(wr_sram_waddr), .fl_wr_pop(fl_wr_pop),
        .wr_sram_re(wr_sram_re), .wr_sram_raddr(wr_sram_raddr), .wr_full(wr_full),
        .wr_empty(wr_empty), .wr_fill(wr_fill)
    );

    // Behavioural SRAM with one cycle of read latency
    always @(posedge clk) begin
        if (rd_sram_we) mem[rd_sram_waddr] <= push_data;
        if (rd_sram_re) sram_rdata <= mem[rd_sram_raddr];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dat(input int p, input int pass, input int n);
        return DW'(p * 17 + pass * 5 + n);
    endfunction

    task automatic do_cfg(input int v);
        cfg_we   = 1'b1;
        cfg_part = AW'(v);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic wr_push_one(input int exp_addr, input string req);
        bus_wr_push = 1'b1;
        #1;
        check(wr_sram_we == 1'b1, req, int'(wr_sram_we), 1);
        check(int'(wr_sram_waddr) == exp_addr, req, int'(wr_sram_waddr), exp_addr);
        @(negedge clk);
        bus_wr_push = 1'b0;
    endtask

    initial begin
        int rwp, wwp, wrp;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_fill == 0, "R1 rd_fill", int'(rd_fill), 0);
        check(wr_fill == 0, "R1 wr_fill", int'(wr_fill), 0);
        check(!rd_full && !wr_full, "R1 full flags", int'({rd_full, wr_full}), 0);
        check(wr_empty, "R1 wr_empty", int'(wr_empty), 1);
        check(!bus_rvalid, "R1 bus_rvalid", int'(bus_rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_fill == 0 && wr_fill == 0, "R1 fills after release", int'(rd_fill) + int'(wr_fill), 0);
        wr_push_one(DEPTH / 2, "R1 default write base");
        fl_rd_push = 1'b1;
        push_data  = 8'hA5;
        #1;
        check(rd_sram_we && rd_sram_waddr == 0, "R1 first read-side address", int'(rd_sram_waddr), 0);
        @(negedge clk);
        fl_rd_push = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_rvalid && bus_rdata == 8'hA5, "R5 first word held", int'(bus_rdata), 'hA5);

        // R8 illegal boundaries leave everything alone
        do_cfg(0);
        check(wr_fill == 1, "R8 zero boundary kept write fill", int'(wr_fill), 1);
        check(rd_fill == 1 && bus_rvalid, "R8 zero boundary kept read fill", int'(rd_fill), 1);
        do_cfg(DEPTH - 1);
        check(wr_fill == 1, "R8 all-ones boundary kept write fill", int'(wr_fill), 1);
        wr_push_one(DEPTH / 2 + 1, "R8 write base and pointer unchanged");

        for (int p = 1; p <= DEPTH - 2; p++) begin
            int cap;
            cap = DEPTH - p;
            do_cfg(p);
            // R7 clear on legal boundary write
            check(rd_fill == 0 && !bus_rvalid, "R7 read side cleared", int'(rd_fill), 0);
            check(wr_fill == 0 && wr_empty, "R7 write side cleared", int'(wr_fill), 0);
            rwp = 0; wwp = 0; wrp = 0;
            for (int pass = 0; pass < 2; pass++) begin
                // Read FIFO fill
                for (int i = 0; i <= p; i++) begin
                    check(!rd_full, "R2 not full before capacity", int'(rd_full), 0);
                    fl_rd_push = 1'b1;
                    push_data  = dat(p, pass, i);
                    #1;
                    check(rd_sram_we && int'(rd_sram_waddr) == rwp, "R4 read-side store address",
                          int'(rd_sram_waddr), rwp);
                    rwp = (rwp + 1) % p;
                    @(negedge clk);
                    fl_rd_push = 1'b0;
                    check(int'(rd_fill) == i + 1, "R6 read fill level", int'(rd_fill), i + 1);
                end
                check(rd_full, "R2 full at boundary+1", int'(rd_full), 1);
                fl_rd_push = 1'b1;
                #1;
                check(!rd_sram_we, "R2 push when full no store", int'(rd_sram_we), 0);
                @(negedge clk);
                fl_rd_push = 1'b0;
                check(int'(rd_fill) == p + 1, "R2 fill unchanged after extra push", int'(rd_fill), p + 1);

                // Write FIFO fill
                for (int i = 0; i < cap; i++) begin
                    check(!wr_full, "R3 not full before capacity", int'(wr_full), 0);
                    wr_push_one(p + wwp, "R4 write-side store address");
                    wwp = (wwp + 1) % cap;
                    check(int'(wr_fill) == i + 1, "R6 write fill level", int'(wr_fill), i + 1);
                end
                check(wr_full, "R3 full at capacity", int'(wr_full), 1);
                bus_wr_push = 1'b1;
                #1;
                check(!wr_sram_we, "R3 push when full no store", int'(wr_sram_we), 0);
                @(negedge clk);
                bus_wr_push = 1'b0;
                check(int'(wr_fill) == cap % DEPTH, "R3 fill unchanged after extra push", int'(wr_fill), cap);

                // R5 stalled bus keeps oldest word
                repeat (4) @(negedge clk);
                check(bus_rvalid && bus_rdata == dat(p, pass, 0), "R5 held word under stall",
                      int'(bus_rdata), int'(dat(p, pass, 0)));

                // Read FIFO drain
                begin
                    int n;
                    int t;
                    n = 0; t = 0;
                    while (n <= p && t < 200) begin
                        bus_rd_pop = 1'b0;
                        if (bus_rvalid) begin
                            check(bus_rdata == dat(p, pass, n), "R5 read order",
                                  int'(bus_rdata), int'(dat(p, pass, n)));
                            bus_rd_pop = 1'b1;
                            n++;
                        end
                        @(negedge clk);
                        t++;
                    end
                    bus_rd_pop = 1'b0;
                    check(n == p + 1, "R2 words drained", n, p + 1);
                end
                repeat (3) @(negedge clk);
                check(rd_fill == 0 && !bus_rvalid, "R6 read side empty after drain", int'(rd_fill), 0);

                // Write FIFO drain
                for (int i = 0; i < cap; i++) begin
                    fl_wr_pop = 1'b1;
                    #1;
                    check(wr_sram_re && int'(wr_sram_raddr) == p + wrp, "R4 write-side fetch address",
                          int'(wr_sram_raddr), p + wrp);
                    wrp = (wrp + 1) % cap;
                    @(negedge clk);
                    fl_wr_pop = 1'b0;
                    check(int'(wr_fill) == cap - 1 - i, "R6 write fill on pop", int'(wr_fill), cap - 1 - i);
                end
                check(wr_empty, "R3 empty after drain", int'(wr_empty), 1);
                fl_wr_pop = 1'b1;
                #1;
                check(!wr_sram_re, "R3 pop when empty no fetch", int'(wr_sram_re), 0);
                @(negedge clk);
                fl_wr_pop = 1'b0;
                check(wr_fill == 0, "R3 fill unchanged after empty pop", int'(wr_fill), 0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule